// File: doc/BRIEF.md
# Lowest-Priority Short-Command Data Queue

This block collects 8-bit words that arrive on an external port with a write strobe and holds them in a first-in first-out store of 1024 entries. While it holds at least one word it asks for the shared command channel. It sits below every trigger channel in priority, so an external arbiter grants it only slots that nobody else wants. Each granted slot carries the oldest stored word as one short command.

A slot ends in one of two ways. The serializer can report that the command completed, and only then is the word removed. A higher-priority source can instead take the channel mid-command. In that case the word stays at the head and goes out first at the next grant. A sticky cancellation flag records that this happened. A second sticky flag records any word that was dropped because the store was full. Full and empty levels are also reported. The host clears both sticky flags with a single pulse.

Top module: `short_cmd_queue`

## Requirements
- R1: Every `wr_stb` cycle in which `full` is low stores `wr_data`. Stored words leave in the order they were written.
- R2: `empty` is high exactly when no word is stored. `full` is high exactly when 1024 words (parameter DEPTH) are stored. Both update on the clock edge after the write or removal that changes them.
- R3: `req` is high exactly when `empty` is low.
- R4: A one-cycle `grant` while `cmd_active` is low and the store is not empty raises `cmd_active` on the next cycle. `cmd_data` then shows the oldest stored word.
- R5: `slot_end` while `cmd_active` is high removes the head word and drops `cmd_active` on the next cycle. The next grant then carries the following word.
- R6: `preempt` while `cmd_active` is high drops `cmd_active` on the next cycle and keeps the head word, which is carried again by the next grant. When `preempt` and `slot_end` coincide, `preempt` wins and nothing is removed.
- R7: `cancelled` is set on the cycle after an active slot is preempted. It stays set until a `clr_flags` pulse. A set and a clear in the same cycle leave it set.
- R8: A `wr_stb` while `full` is high is discarded, even when a removal happens in the same cycle. `overflow` is set the next cycle and stays set until `clr_flags`, with a coinciding set winning.
- R9: A `grant` while the store is empty, or while a slot is already active, has no effect. `cmd_active` and the stored contents stay as they were.
- R10: After reset `empty` is 1, and `full`, `req`, `cmd_active`, `cancelled` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 8 | Word to store |
| clr_flags | input | 1 | Clears the sticky cancelled and overflow flags |
| grant | input | 1 | Arbiter starts a slot for this source |
| slot_end | input | 1 | Serializer reports the current command completed |
| preempt | input | 1 | Higher-priority source cut the current command |
| req | output | 1 | Channel request, high while words are stored |
| cmd_active | output | 1 | A slot is in progress for this source |
| cmd_data | output | 8 | Oldest stored word, the command to send |
| full | output | 1 | Store holds DEPTH words |
| empty | output | 1 | Store holds no word |
| cancelled | output | 1 | Sticky: a slot was preempted |
| overflow | output | 1 | Sticky: a word was dropped while full |

## Verification
A new word can arrive in the same cycle that a completed slot removes the head. The bench does this first with a part-filled store, where the count must stay level. It then repeats it with a full store, where the incoming word must be dropped and `overflow` raised even though a place is freed. A full drain then shows that the stored order skipped the dropped word. Preemption can also coincide with completion, and separately with a flag clear. The bench drives each pair in one cycle and checks that the head word is carried again and that `cancelled` ends up set.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic {
        SL_IDLE = 1'b0,
        SL_SEND = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic take;    // slot completed, remove head
        logic abort;   // slot cut by a higher-priority source
    } slot_evt_t;

    localparam int FLAG_CANCEL = 0;
    localparam int FLAG_OVFL   = 1;
    localparam int NUM_STICKY  = 2;

    function automatic logic [31:0] wrap_inc(input logic [31:0] p, input int unsigned depth);
        return (p == depth - 1) ? 32'd0 : p + 32'd1;
    endfunction

endpackage

// File: rtl/sq_store.sv
module sq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty,
    output logic          dropped
);
    import sq_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = push && !full;
    assign do_rd   = pop && !empty;
    assign dropped = push && full;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
            if (do_rd) rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sq_slot_ctrl.sv
module sq_slot_ctrl (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 grant,
    input  logic                 slot_end,
    input  logic                 preempt,
    input  logic                 empty,
    output logic                 active,
    output sq_pkg::slot_evt_t    evt
);
    import sq_pkg::*;

    slot_state_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        evt       = '0;
        unique case (state_q)
            SL_IDLE: if (grant && !empty) state_d = SL_SEND;
            SL_SEND: begin
                if (preempt) begin
                    evt.abort = 1'b1;
                    state_d   = SL_IDLE;
                end else if (slot_end) begin
                    evt.take  = 1'b1;
                    state_d   = SL_IDLE;
                end
            end
            default: state_d = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SL_IDLE;
        else     state_q <= state_d;
    end

    assign active = (state_q == SL_SEND);

endmodule

// File: rtl/sq_sticky.sv
module sq_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/short_cmd_queue.sv
module short_cmd_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_flags,
    input  logic          grant,
    input  logic          slot_end,
    input  logic          preempt,
    output logic          req,
    output logic          cmd_active,
    output logic [DW-1:0] cmd_data,
    output logic          full,
    output logic          empty,
    output logic          cancelled,
    output logic          overflow
);
    import sq_pkg::*;

    slot_evt_t             evt;
    logic                  dropped;
    logic [NUM_STICKY-1:0] set_v, flag_v;

    sq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .push(wr_stb), .push_data(wr_data),
        .pop(evt.take),
        .head(cmd_data), .full(full), .empty(empty), .dropped(dropped)
    );

    sq_slot_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .grant(grant), .slot_end(slot_end), .preempt(preempt),
        .empty(empty), .active(cmd_active), .evt(evt)
    );

    always_comb begin
        set_v              = '0;
        set_v[FLAG_CANCEL] = evt.abort;
        set_v[FLAG_OVFL]   = dropped;
    end

    sq_sticky #(.N(NUM_STICKY)) u_flags (
        .clk(clk), .rst(rst), .clr(clr_flags), .set(set_v), .flags(flag_v)
    );

    assign cancelled = flag_v[FLAG_CANCEL];
    assign overflow  = flag_v[FLAG_OVFL];
    assign req       = !empty;

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_stb,
    input logic          clr_flags,
    input logic          grant,
    input logic          slot_end,
    input logic          preempt,
    input logic          req,
    input logic          cmd_active,
    input logic [DW-1:0] cmd_data,
    input logic          full,
    input logic          empty,
    input logic          cancelled,
    input logic          overflow
);
    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));  // R2
    AST_WRITE_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        wr_stb && !full |=> req);  // R3
    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (rst)
        grant && !cmd_active && !empty |=> cmd_active);  // R4
    AST_END_CLOSES: assert property (@(posedge clk) disable iff (rst)
        cmd_active && slot_end |=> !cmd_active);  // R5
    AST_PREEMPT_KEEPS_HEAD: assert property (@(posedge clk) disable iff (rst)
        cmd_active && preempt |=> !cmd_active && $stable(cmd_data) && !empty);  // R6
    AST_CANCEL_STICKY: assert property (@(posedge clk) disable iff (rst)
        cmd_active && preempt |=> cancelled);  // R7
    AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cancelled && !clr_flags |=> cancelled);  // R7
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (rst)
        wr_stb && full |=> overflow);  // R8
    AST_NO_SLOT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        empty |-> !cmd_active);  // R9

endmodule

bind short_cmd_queue sq_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .clr_flags(clr_flags),
    .grant(grant), .slot_end(slot_end), .preempt(preempt), .req(req),
    .cmd_active(cmd_active), .cmd_data(cmd_data), .full(full),
    .empty(empty), .cancelled(cancelled), .overflow(overflow)
);

// File: tb/sim_short_cmd_queue.sv
module sim_short_cmd_queue;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic       clk = 1'b0;
    logic       rst, wr_stb, clr_flags, grant, slot_end, preempt;
    logic [7:0] wr_data;
    logic       req, cmd_active, full, empty, cancelled, overflow;
    logic [7:0] cmd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    short_cmd_queue #(.DW(8), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .clr_flags(clr_flags), .grant(grant), .slot_end(slot_end),
        .preempt(preempt), .req(req), .cmd_active(cmd_active),
        .cmd_data(cmd_data), .full(full), .empty(empty),
        .cancelled(cancelled), .overflow(overflow)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = b;
        @(negedge clk);
        wr_stb = 1'b0;
        if (model.size() < DEPTH) model.push_back(b);
    endtask

    // mode 0: complete, 1: preempt, 2: both in one cycle
    task automatic slot(input int mode, input string rq);
        logic [7:0] exp_b;
        exp_b = model[0];
        @(negedge clk);
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        check({rq, " active"}, 32'(cmd_active), 32'd1);
        check({rq, " data"}, 32'(cmd_data), 32'(exp_b));
        slot_end = (mode != 1);
        preempt  = (mode != 0);
        @(negedge clk);
        slot_end = 1'b0; preempt = 1'b0;
        check({rq, " closed"}, 32'(cmd_active), 32'd0);
        if (mode == 0) void'(model.pop_front());
    endtask

    task automatic pulse_clr;
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 empty", 32'(empty), 32'd1);
        check("R10 full", 32'(full), 32'd0);
        check("R10 req", 32'(req), 32'd0);
        check("R10 active", 32'(cmd_active), 32'd0);
        check("R10 cancelled", 32'(cancelled), 32'd0);
        check("R10 overflow", 32'(overflow), 32'd0);
    endtask

    task automatic t_order;
        push(8'h11); push(8'h22); push(8'h33);
        check("R3 req", 32'(req), 32'd1);
        check("R2 not empty", 32'(empty), 32'd0);
        slot(0, "R1 R4 R5 first");
        slot(0, "R1 R5 second");
        slot(0, "R1 R5 third");
        check("R2 empty after drain", 32'(empty), 32'd1);
        check("R3 req low", 32'(req), 32'd0);
    endtask

    task automatic t_idle_grant;
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b0;
        check("R9 grant when empty", 32'(cmd_active), 32'd0);
        push(8'h44); push(8'h55);
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b1;   // second grant during the slot
        check("R9 active", 32'(cmd_active), 32'd1);
        @(negedge clk); grant = 1'b0;
        check("R9 grant during slot", 32'(cmd_data), 32'h44);
        slot_end = 1'b1;
        @(negedge clk); slot_end = 1'b0;
        void'(model.pop_front());
        check("R9 one removal", 32'(cmd_data), 32'h55);
        slot(0, "R9 tail");
    endtask

    task automatic t_preempt;
        push(8'hA1); push(8'hA2);
        slot(1, "R6 preempted");
        check("R7 cancelled set", 32'(cancelled), 32'd1);
        slot(2, "R6 preempt and end");
        check("R6 head kept", 32'(cmd_data), 32'hA1);
        slot(0, "R6 resend");
        check("R6 next word", 32'(cmd_data), 32'hA2);
        check("R7 sticky", 32'(cancelled), 32'd1);
        pulse_clr();
        check("R7 cleared", 32'(cancelled), 32'd0);
        // preempt coinciding with clear: set wins
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b0; preempt = 1'b1; clr_flags = 1'b1;
        @(negedge clk); preempt = 1'b0; clr_flags = 1'b0;
        check("R7 set wins over clear", 32'(cancelled), 32'd1);
        slot(0, "R6 final");
        pulse_clr();
    endtask

    task automatic t_same_cycle_rw;
        push(8'hC0); push(8'hC1);
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b0; slot_end = 1'b1; wr_stb = 1'b1; wr_data = 8'hC2;
        @(negedge clk); slot_end = 1'b0; wr_stb = 1'b0;
        void'(model.pop_front()); model.push_back(8'hC2);
        check("R1 head after write+pop", 32'(cmd_data), 32'hC1);
        slot(0, "R1 C1");
        slot(0, "R1 C2");
        check("R2 empty", 32'(empty), 32'd1);
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) push(8'(i * 7 + 3));
        check("R2 full", 32'(full), 32'd1);
        check("R8 no overflow yet", 32'(overflow), 32'd0);
        push(8'hEE);
        check("R8 overflow", 32'(overflow), 32'd1);
        check("R8 still full", 32'(full), 32'd1);
        // strobe at full coinciding with a completed slot is dropped
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b0; slot_end = 1'b1; wr_stb = 1'b1; wr_data = 8'hEF;
        @(negedge clk); slot_end = 1'b0; wr_stb = 1'b0;
        void'(model.pop_front());
        check("R8 dropped at full with pop", 32'(full), 32'd0);
        pulse_clr();
        check("R8 cleared", 32'(overflow), 32'd0);
        push(8'h5A);
        check("R2 full again", 32'(full), 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            check("R1 drain order", 32'(cmd_data), 32'(model[0]));
            @(negedge clk); grant = 1'b1;
            @(negedge clk); grant = 1'b0; slot_end = 1'b1;
            @(negedge clk); slot_end = 1'b0;
            void'(model.pop_front());
        end
        check("R2 empty after full drain", 32'(empty), 32'd1);
        check("R8 stays clear", 32'(overflow), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_stb = 1'b0; wr_data = '0; clr_flags = 1'b0;
        grant = 1'b0; slot_end = 1'b0; preempt = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_idle_grant();
        t_preempt();
        t_same_cycle_rw();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule